// File: doc/BRIEF.md
# VRAM Block-Copy DMA Engine

This block copies bytes from anywhere in the 16-bit address space into the 8 KiB video RAM window at 0x8000. Software loads a source address and a destination address, each as a high and a low byte register, and then writes a control byte. That control write either starts the copy or arms it. In general mode the whole length moves at once. In horizontal-blank mode one 16-byte block moves each time the display enters its blanking period. The block reads a byte and then writes it, so each byte takes two cycles. The CPU stall output stays high for as long as a block is in flight.

The engine sees the display only through two inputs: an LCD-enable flag and a two-bit display mode, where mode 0 means horizontal blank. When a block ends, the engine writes the advanced source and destination pointers back into the address registers. The control register then reads back the number of blocks still to come, and reads 0xFF once the transfer is complete.

Memory access goes out through two valid/ready channels, one for reads and one for writes. A read returns its data in the same cycle as its handshake (`mem_rd_valid && mem_rd_ready`). While valid is high and ready is low, the engine holds valid, address and data steady. Back-pressure only stretches the transfer. It never drops or repeats a byte.

Top module: `vram_blit_engine`

## Requirements
- R1: After reset the four address registers (select 0 = source high, 1 = source low, 2 = destination high, 3 = destination low) read 0x00, the control register (select 4) reads 0xFF, and `cpu_stall`, `mem_rd_valid` and `mem_wr_valid` are low.
- R2: A transfer reads from ({src_hi,src_lo} with bits 3:0 cleared) and then from each following address in turn, incrementing modulo 2^16. Each byte read is written out unchanged.
- R3: The destination starts at 0x8000 | ({dst_hi,dst_lo} & 0x1FF0). It increments within bits 12:0 and wraps from 0x9FFF to 0x8000, so every write lands in 0x8000–0x9FFF.
- R4: A control write is rejected when the masked source lies in 0x8000–0x9FFF. On rejection there is no memory traffic, no stall, the address registers do not change, and the control register reads the written value with bit 7 set.
- R5: A control write with bit 7 = 0, made while horizontal-blank mode is idle, starts a general copy of (bits 6:0 + 1) × 16 bytes in the cycle after the write. When ready is held high, each byte takes one read cycle followed by one write cycle, and `cpu_stall` is high for exactly 2 cycles per byte.
- R6: At the end of every block, the address registers read back the advanced source and the advanced (wrapped) destination. Destination high keeps bit 7 set.
- R7: When a general copy completes, the control register reads 0xFF.
- R8: A control write with bit 7 = 1, made while the LCD is on and the mode is 0, moves one 16-byte block at once. The control register reads bits 6:0 of the written value and drops by one after each block. When it reaches 0xFF the mode ends and no further blocks move.
- R9: A horizontal-blank request made while the mode is not 0 moves nothing until the mode next enters 0. After that it moves one block per entry into mode 0, and nothing while the mode stays at 0.
- R10: A horizontal-blank request with the LCD off reads back 0x80 | ((value + 1) & 0x7F). It moves nothing and stays unarmed, even if the LCD later turns on and enters mode 0.
- R11: A control write with bit 7 = 0, made while horizontal-blank mode is armed, cancels that mode without starting any copy. The control register then reads 0x80 | the remaining count.
- R12: A read or write request stays valid, with stable address and data, until it is accepted. Back-pressure changes neither the bytes moved nor their order.
- R13: Register writes made while `cpu_stall` is high are ignored. A control write at that time does not restart or lengthen the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 src hi, 1 src lo, 2 dst hi, 3 dst lo, 4 control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the selected register (combinational; 0xFF for unused selects) |
| lcd_on | input | 1 | Display enabled |
| lcd_mode | input | 2 | Display mode; 0 is horizontal blank |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted, data valid this cycle |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Write request accepted |
| mem_wr_addr | output | 16 | Write address (always 0x8000–0x9FFF) |
| mem_wr_data | output | 8 | Write data |
| cpu_stall | output | 1 | High while a block is in flight |

## Verification
A bad byte counter shows up as a write count that differs from (n+1)×16. It also shows up in the control readback one cycle after the last write. A corrupted pointer or a broken mask appears on the very next memory request as a wrong address. It appears again at block end, when the written-back register values are wrong. Bad mode or pacing state is visible within one blanking entry: a block moves when none was due, or a due block never arrives and the count stays stuck. Handshake faults appear within a cycle as an address that moves while valid is high and ready is low.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } vdma_sel_e;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_e;

  // Outcome of a control write, in decode priority order
  typedef enum logic [2:0] {
    CW_REJECT  = 3'd0,
    CW_CANCEL  = 3'd1,
    CW_GENERAL = 3'd2,
    CW_LCD_OFF = 3'd3,
    CW_HB_NOW  = 3'd4,
    CW_HB_ARM  = 3'd5
  } cw_kind_e;

  localparam logic [1:0] HBLANK_MODE = 2'd0;

endpackage

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 12,
  parameter int VRAM_OFS_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] end_src_o,
  output logic [ADDR_W-1:0] end_dst_o
);

  localparam logic [CNT_W-1:0]      CNT_ONE = CNT_W'(1);
  localparam logic [VRAM_OFS_W-1:0] OFS_ONE = VRAM_OFS_W'(1);

  mv_state_e         st_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] buf_q;
  logic [ADDR_W-1:0] src_nxt, dst_nxt;
  logic              wr_fire;

  assign src_nxt = src_q + ADDR_W'(1);
  // destination wraps inside the video RAM window
  assign dst_nxt = {dst_q[ADDR_W-1:VRAM_OFS_W], dst_q[VRAM_OFS_W-1:0] + OFS_ONE};
  assign wr_fire = (st_q == MV_WRITE) && wr_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= MV_IDLE;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      buf_q <= '0;
    end else begin
      case (st_q)
        MV_IDLE: begin
          if (start_i) begin
            src_q <= src_i;
            dst_q <= dst_i;
            cnt_q <= len_i;
            st_q  <= MV_READ;
          end
        end
        MV_READ: begin
          if (rd_ready_i) begin
            buf_q <= rd_data_i;
            st_q  <= MV_WRITE;
          end
        end
        MV_WRITE: begin
          if (wr_ready_i) begin
            src_q <= src_nxt;
            dst_q <= dst_nxt;
            cnt_q <= cnt_q - CNT_ONE;
            st_q  <= (cnt_q == CNT_ONE) ? MV_IDLE : MV_READ;
          end
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  assign rd_valid_o = (st_q == MV_READ);
  assign rd_addr_o  = src_q;
  assign wr_valid_o = (st_q == MV_WRITE);
  assign wr_addr_o  = dst_q;
  assign wr_data_o  = buf_q;
  assign busy_o     = (st_q != MV_IDLE);
  assign done_o     = wr_fire && (cnt_q == CNT_ONE);
  assign end_src_o  = src_nxt;
  assign end_dst_o  = dst_nxt;

endmodule

// File: rtl/vdma_pacer.sv
module vdma_pacer
  import vdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lcd_on_i,
  input  logic [1:0] lcd_mode_i,
  input  logic       armed_i,
  input  logic       busy_i,
  input  logic       taken_i,
  output logic       fire_o
);

  logic in_hb, prev_hb_q, pend_q, entry, cand;

  assign in_hb = lcd_on_i && (lcd_mode_i == HBLANK_MODE);
  assign entry = in_hb && !prev_hb_q;
  // a block is owed for this blanking period until one has started
  assign cand   = (pend_q || entry) && armed_i && in_hb;
  assign fire_o = cand && !busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_hb_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      prev_hb_q <= in_hb;
      pend_q    <= cand && !taken_i;
    end
  end

endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int BLK_BYTES  = 16,
  parameter int CNT_W      = 12,
  parameter int VRAM_OFS_W = 13,
  parameter int VRAM_BASE  = 'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [2:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              lcd_on_i,
  input  logic [1:0]        lcd_mode_i,
  input  logic              busy_i,
  input  logic              hb_fire_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] end_src_i,
  input  logic [ADDR_W-1:0] end_dst_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_src_o,
  output logic [ADDR_W-1:0] start_dst_o,
  output logic [CNT_W-1:0]  start_len_o,
  output logic              armed_o
);

  localparam int                ALIGN_W  = $clog2(BLK_BYTES);
  localparam int                LEN_W    = DATA_W - 1;
  localparam logic [ADDR_W-1:0] ALIGN_M  = ~ADDR_W'(BLK_BYTES - 1);
  localparam logic [ADDR_W-1:0] OFS_M    = ADDR_W'((1 << VRAM_OFS_W) - 1);
  localparam logic [ADDR_W-1:0] DST_M    = ALIGN_M & OFS_M;
  localparam logic [ADDR_W-1:0] VBASE    = ADDR_W'(VRAM_BASE);
  localparam logic [CNT_W-1:0]  BLK_LEN  = CNT_W'(BLK_BYTES);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [DATA_W-1:0] CTRL_ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] MSB      = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, ctrl_q;
  logic              hb_q;

  logic [ADDR_W-1:0] src_full, dst_full;
  logic              src_bad, ctl_wr, want_hb, wr_start, hb_start;
  logic [LEN_W-1:0]  len_f, len_bump;
  logic [CNT_W-1:0]  gen_len;
  cw_kind_e          kind;

  assign src_full = {src_hi_q, src_lo_q} & ALIGN_M;
  assign dst_full = VBASE | ({dst_hi_q, dst_lo_q} & DST_M);
  assign src_bad  = (src_full[ADDR_W-1:VRAM_OFS_W] == VBASE[ADDR_W-1:VRAM_OFS_W]);
  assign ctl_wr   = wr_en_i && !busy_i && (sel_i == SEL_CTRL);
  assign want_hb  = wdata_i[DATA_W-1];
  assign len_f    = wdata_i[LEN_W-1:0];
  assign len_bump = len_f + LEN_ONE;
  assign gen_len  = {({1'b0, len_f} + {1'b0, LEN_ONE}), {ALIGN_W{1'b0}}};

  always_comb begin
    if (src_bad)                            kind = CW_REJECT;
    else if (hb_q && !want_hb)              kind = CW_CANCEL;
    else if (!want_hb)                      kind = CW_GENERAL;
    else if (!lcd_on_i)                     kind = CW_LCD_OFF;
    else if (lcd_mode_i == HBLANK_MODE)     kind = CW_HB_NOW;
    else                                    kind = CW_HB_ARM;
  end

  assign wr_start    = ctl_wr && ((kind == CW_GENERAL) || (kind == CW_HB_NOW));
  assign hb_start    = hb_fire_i && !ctl_wr;
  assign start_o     = wr_start || hb_start;
  assign start_src_o = src_full;
  assign start_dst_o = dst_full;
  assign start_len_o = (wr_start && (kind == CW_GENERAL)) ? gen_len : BLK_LEN;
  assign armed_o     = hb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
      ctrl_q   <= '1;
      hb_q     <= 1'b0;
    end else if (ctl_wr) begin
      case (kind)
        CW_REJECT:  ctrl_q <= wdata_i | MSB;
        CW_CANCEL: begin
          ctrl_q <= ctrl_q | MSB;
          hb_q   <= 1'b0;
        end
        CW_GENERAL: begin
          ctrl_q <= {1'b0, len_f};
          hb_q   <= 1'b0;
        end
        CW_LCD_OFF: begin
          ctrl_q <= {1'b1, len_bump};
          hb_q   <= 1'b0;
        end
        default: begin
          ctrl_q <= {1'b0, len_f};
          hb_q   <= 1'b1;
        end
      endcase
    end else if (done_i) begin
      src_hi_q <= end_src_i[ADDR_W-1:DATA_W];
      src_lo_q <= end_src_i[DATA_W-1:0];
      dst_hi_q <= end_dst_i[ADDR_W-1:DATA_W];
      dst_lo_q <= end_dst_i[DATA_W-1:0];
      if (hb_q) begin
        ctrl_q <= ctrl_q - CTRL_ONE;
        if (ctrl_q == '0) hb_q <= 1'b0;
      end else begin
        ctrl_q <= '1;
      end
    end else if (wr_en_i && !busy_i) begin
      case (sel_i)
        SEL_SRC_HI: src_hi_q <= wdata_i;
        SEL_SRC_LO: src_lo_q <= wdata_i;
        SEL_DST_HI: dst_hi_q <= wdata_i;
        SEL_DST_LO: dst_lo_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_SRC_HI: rdata_o = src_hi_q;
      SEL_SRC_LO: rdata_o = src_lo_q;
      SEL_DST_HI: rdata_o = dst_hi_q;
      SEL_DST_LO: rdata_o = dst_lo_q;
      SEL_CTRL:   rdata_o = ctrl_q;
      default:    rdata_o = '1;
    endcase
  end

endmodule

// File: rtl/vram_blit_engine.sv
module vram_blit_engine
  import vdma_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BLK_BYTES  = 16,
  parameter int VRAM_OFS_W = 13,
  parameter int VRAM_BASE  = 'h8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [2:0]            cfg_sel,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  input  logic                  lcd_on,
  input  logic [1:0]            lcd_mode,
  output logic                  mem_rd_valid,
  input  logic                  mem_rd_ready,
  output logic [2*DATA_W-1:0]   mem_rd_addr,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic                  mem_wr_valid,
  input  logic                  mem_wr_ready,
  output logic [2*DATA_W-1:0]   mem_wr_addr,
  output logic [DATA_W-1:0]     mem_wr_data,
  output logic                  cpu_stall
);

  localparam int ADDR_W  = 2 * DATA_W;
  localparam int ALIGN_W = $clog2(BLK_BYTES);
  localparam int CNT_W   = DATA_W + ALIGN_W;

  logic              start, busy, done, hb_fire, armed;
  logic [ADDR_W-1:0] start_src, start_dst, end_src, end_dst;
  logic [CNT_W-1:0]  start_len;

  vdma_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W),
    .VRAM_OFS_W(VRAM_OFS_W), .VRAM_BASE(VRAM_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(cfg_wr_en), .sel_i(cfg_sel), .wdata_i(cfg_wdata), .rdata_o(cfg_rdata),
    .lcd_on_i(lcd_on), .lcd_mode_i(lcd_mode),
    .busy_i(busy), .hb_fire_i(hb_fire), .done_i(done),
    .end_src_i(end_src), .end_dst_i(end_dst),
    .start_o(start), .start_src_o(start_src), .start_dst_o(start_dst),
    .start_len_o(start_len), .armed_o(armed)
  );

  vdma_pacer u_pacer (
    .clk(clk), .rst_n(rst_n),
    .lcd_on_i(lcd_on), .lcd_mode_i(lcd_mode),
    .armed_i(armed), .busy_i(busy), .taken_i(start),
    .fire_o(hb_fire)
  );

  vdma_mover #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .VRAM_OFS_W(VRAM_OFS_W)
  ) u_mover (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .src_i(start_src), .dst_i(start_dst), .len_i(start_len),
    .rd_valid_o(mem_rd_valid), .rd_ready_i(mem_rd_ready),
    .rd_addr_o(mem_rd_addr), .rd_data_i(mem_rd_data),
    .wr_valid_o(mem_wr_valid), .wr_ready_i(mem_wr_ready),
    .wr_addr_o(mem_wr_addr), .wr_data_o(mem_wr_data),
    .busy_o(busy), .done_o(done),
    .end_src_o(end_src), .end_dst_o(end_dst)
  );

  assign cpu_stall = busy;

endmodule

// File: rtl/vdma_checker.sv
module vdma_checker #(
  parameter int DATA_W     = 8,
  parameter int VRAM_OFS_W = 13,
  parameter int VRAM_BASE  = 'h8000
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_rd_valid,
  input logic                mem_rd_ready,
  input logic [2*DATA_W-1:0] mem_rd_addr,
  input logic                mem_wr_valid,
  input logic                mem_wr_ready,
  input logic [2*DATA_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0]   mem_wr_data,
  input logic                cpu_stall
);

  localparam int                  ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0]   VBASE  = ADDR_W'(VRAM_BASE);

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && mem_wr_valid));

  p_traffic_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid) |-> cpu_stall);

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ready |=> mem_wr_valid);

  p_dst_in_vram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr[ADDR_W-1:VRAM_OFS_W] == VBASE[ADDR_W-1:VRAM_OFS_W]));

endmodule

bind vram_blit_engine vdma_checker #(
  .DATA_W(DATA_W), .VRAM_OFS_W(VRAM_OFS_W), .VRAM_BASE(VRAM_BASE)
) i_vdma_checker (
  .clk(clk), .rst_n(rst_n),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .cpu_stall(cpu_stall)
);

// File: tb/test_vram_blit_engine.sv
module test_vram_blit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_N      = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        lcd_on;
  logic [1:0]  lcd_mode;
  logic        mem_rd_valid, mem_rd_ready;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [15:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        cpu_stall;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  int scount = 0;
  logic        bp_en = 1'b0;
  logic [31:0] cyc = '0;
  logic [15:0] wa [0:LOG_N-1];
  logic [7:0]  wd [0:LOG_N-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] exp_src(input logic [15:0] s, input int i);
    return (s & 16'hFFF0) + 16'(i);
  endfunction

  function automatic logic [15:0] exp_dst(input logic [15:0] d, input int i);
    return 16'h8000 | (((d & 16'h1FF0) + 16'(i)) & 16'h1FFF);
  endfunction

  assign mem_rd_data  = pat(mem_rd_addr);
  assign mem_rd_ready = !bp_en || (cyc % 3 == 1);
  assign mem_wr_ready = !bp_en || (cyc % 4 == 2);

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_wr_valid && mem_wr_ready) begin
        wa[wcount % LOG_N] = mem_wr_addr;
        wd[wcount % LOG_N] = mem_wr_data;
        wcount = wcount + 1;
      end
      if (cpu_stall) scount = scount + 1;
    end
  end

  vram_blit_engine i_vram_blit_engine (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lcd_on(lcd_on), .lcd_mode(lcd_mode),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .cpu_stall(cpu_stall)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] s, input int exp, input string req, input string what);
    cfg_sel = s;
    #1;
    chk_eq(req, what, int'(cfg_rdata), exp);
  endtask

  task automatic set_addr(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]);
    wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]);
    wr_reg(3'd3, d[7:0]);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && cpu_stall; k++) @(negedge clk);
    idle(2);
  endtask

  // compares logged writes [from, from+n) with the expected copy
  task automatic check_span(input string req, input int from, input int n,
                            input logic [15:0] s, input logic [15:0] d);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (wa[(from + i) % LOG_N] !== exp_dst(d, i)) bad++;
      if (wd[(from + i) % LOG_N] !== pat(exp_src(s, i))) bad++;
    end
    chk_eq(req, "mismatched address/data bytes", bad, 0);
  endtask

  task automatic gen_run(input logic [15:0] s, input logic [15:0] d, input logic [6:0] n,
                         input bit bp);
    int bw, bs, nb;
    logic [15:0] es, ed;
    nb = (int'(n) + 1) * 16;
    set_addr(s, d);
    bw = wcount; bs = scount;
    wr_reg(3'd4, {1'b0, n});
    wait_idle();
    chk_eq("R5", "general byte count", wcount - bw, nb);
    check_span(bp ? "R12" : "R2", bw, nb, s, d);
    if (!bp) chk_eq("R5", "stall cycles", scount - bs, 2 * nb);
    expect_reg(3'd4, 8'hFF, "R7", "control after general");
    es = exp_src(s, nb);
    ed = exp_dst(d, nb);
    expect_reg(3'd0, es[15:8], "R6", "src hi writeback");
    expect_reg(3'd1, es[7:0],  "R6", "src lo writeback");
    expect_reg(3'd2, ed[15:8], "R6", "dst hi writeback");
    expect_reg(3'd3, ed[7:0],  "R6", "dst lo writeback");
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int bw, bs;
    logic [15:0] srcs [4] = '{16'h0000, 16'h7FF7, 16'hA123, 16'hFFF5};
    logic [15:0] dsts [4] = '{16'h0000, 16'h9FF8, 16'h3456, 16'hFFFF};
    logic [6:0]  lens [8] = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd7, 7'd15, 7'd31, 7'd127};

    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_sel = 3'd0; cfg_wdata = 8'h00;
    lcd_on = 1'b0; lcd_mode = 2'd2;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    expect_reg(3'd0, 0, "R1", "src hi reset");
    expect_reg(3'd1, 0, "R1", "src lo reset");
    expect_reg(3'd2, 0, "R1", "dst hi reset");
    expect_reg(3'd3, 0, "R1", "dst lo reset");
    expect_reg(3'd4, 8'hFF, "R1", "control reset");
    chk_eq("R1", "stall/valid at reset", {cpu_stall, mem_rd_valid, mem_wr_valid}, 0);

    // R2 R3 R5 R6 R7 general sweep over lengths and alignments
    for (int li = 0; li < 8; li++) begin
      gen_run(srcs[li % 4], dsts[(li + li / 4) % 4], lens[li], 1'b0);
    end

    // R12 back-pressure
    bp_en = 1'b1;
    gen_run(16'h4321, 16'h1234, 7'd2, 1'b1);
    bp_en = 1'b0;

    // R4 rejected sources
    for (int k = 0; k < 2; k++) begin
      logic [7:0] hi;
      hi = (k == 0) ? 8'h80 : 8'h9F;
      set_addr({hi, 8'hFB}, 16'h0120);
      bw = wcount; bs = scount;
      wr_reg(3'd4, 8'h12);
      idle(40);
      chk_eq("R4", "writes after rejected source", wcount - bw, 0);
      chk_eq("R4", "stall after rejected source", scount - bs, 0);
      expect_reg(3'd4, 8'h92, "R4", "control readback on reject");
      expect_reg(3'd0, hi, "R4", "src hi unchanged on reject");
    end

    // R13 writes while stalled are ignored
    set_addr(16'h12E0, 16'h0000);
    bw = wcount;
    wr_reg(3'd4, 8'h03);
    wr_reg(3'd0, 8'h55);
    wr_reg(3'd4, 8'h7F);
    wait_idle();
    chk_eq("R13", "bytes with writes during stall", wcount - bw, 64);
    expect_reg(3'd0, 8'h13, "R13", "src hi after ignored write");
    expect_reg(3'd4, 8'hFF, "R13", "control after ignored write");

    // R9 arm outside blanking, then R8 per-entry blocks
    lcd_on = 1'b1; lcd_mode = 2'd2;
    set_addr(16'h5000, 16'h0100);
    bw = wcount; bs = scount;
    wr_reg(3'd4, 8'h82);
    expect_reg(3'd4, 8'h02, "R8", "control readback when armed");
    idle(20);
    chk_eq("R9", "no block before blanking", wcount - bw, 0);
    lcd_mode = 2'd0; idle(40);
    chk_eq("R9", "one block on first entry", wcount - bw, 16);
    expect_reg(3'd4, 8'h01, "R8", "count after first block");
    expect_reg(3'd1, 8'h10, "R6", "src lo after block");
    expect_reg(3'd2, 8'h81, "R6", "dst hi after block");
    expect_reg(3'd3, 8'h10, "R6", "dst lo after block");
    idle(40);
    chk_eq("R9", "no second block in same blanking", wcount - bw, 16);
    lcd_mode = 2'd3; idle(5); lcd_mode = 2'd0; idle(40);
    chk_eq("R9", "second entry block", wcount - bw, 32);
    expect_reg(3'd4, 8'h00, "R8", "count after second block");
    lcd_mode = 2'd2; idle(5); lcd_mode = 2'd0; idle(40);
    chk_eq("R8", "third entry block", wcount - bw, 48);
    expect_reg(3'd4, 8'hFF, "R8", "control when blanking copy done");
    lcd_mode = 2'd2; idle(5); lcd_mode = 2'd0; idle(40);
    chk_eq("R8", "no block after completion", wcount - bw, 48);
    check_span("R2", bw, 48, 16'h5000, 16'h0100);
    chk_eq("R5", "stall cycles over three blocks", scount - bs, 96);

    // R8 immediate start while in blanking
    set_addr(16'h2220, 16'h0040);
    bw = wcount;
    wr_reg(3'd4, 8'h80);
    idle(40);
    chk_eq("R8", "immediate block", wcount - bw, 16);
    check_span("R3", bw, 16, 16'h2220, 16'h0040);
    expect_reg(3'd4, 8'hFF, "R8", "control after single-block request");
    lcd_mode = 2'd2; idle(5); lcd_mode = 2'd0; idle(40);
    chk_eq("R8", "no block after single-block request", wcount - bw, 16);

    // R10 blanking request with LCD off
    lcd_on = 1'b0; lcd_mode = 2'd2;
    bw = wcount;
    wr_reg(3'd4, 8'h85);
    expect_reg(3'd4, 8'h86, "R10", "readback with LCD off");
    wr_reg(3'd4, 8'hFF);
    expect_reg(3'd4, 8'h80, "R10", "readback with LCD off, count wraps");
    lcd_on = 1'b1; idle(5); lcd_mode = 2'd0; idle(40);
    chk_eq("R10", "no transfer after LCD turns on", wcount - bw, 0);

    // R11 cancel while armed in blanking
    lcd_mode = 2'd2;
    set_addr(16'h3000, 16'h0200);
    bw = wcount;
    wr_reg(3'd4, 8'h83);
    lcd_mode = 2'd0; idle(40);
    chk_eq("R11", "block before cancel", wcount - bw, 16);
    wr_reg(3'd4, 8'h05);
    idle(40);
    chk_eq("R11", "no general copy on cancel", wcount - bw, 16);
    expect_reg(3'd4, 8'h82, "R11", "control after cancel");
    lcd_mode = 2'd2; idle(5); lcd_mode = 2'd0; idle(40);
    chk_eq("R11", "no block after cancel", wcount - bw, 16);

    summary();
    $finish;
  end

endmodule